// File: doc/BRIEF.md
# UART Register Front End

This block is the word-addressed register side of a serial port. A simple request/response port carries 32-bit reads and writes. Behind that port sit a control word, a line-format word, a read-only channel status word and a single data address. A write to the data address queues a byte for transmission. A read of the same address takes the oldest received byte. Two byte FIFOs sit inside the block, one for each direction. The bit-level shift engines sit outside it and connect through a byte handshake on each side and a busy input from the transmitter.

Software turns each direction on and off through the control word. It can also empty either FIFO by writing a flush bit that clears itself. It learns whether it may write or read the data address by polling three status flags: transmitter active, transmit queue full and receive queue empty. The line-format word is stored and passed straight out to the shift engines.

Top module: `uart_csr_frontend`

## Requirements
- R1: The control word lives at byte offset 0x00 and has 9 implemented bits, reset to zero. Bit 4 drives `tx_en` and bit 2 drives `rx_en`. Bits 31:9 read as zero.
- R2: Control bit 1 (transmit flush) and bit 0 (receive flush) stay set for exactly one cycle after the write that sets them. In that cycle the matching FIFO is emptied, and any push or pop to it is discarded. Once the bit has cleared it reads back as zero.
- R3: The line-format word lives at offset 0x04, stores bits 10:0 and resets to 0x020 (8 data bits, no parity). Its value drives `mode_cfg`, and bits 31:11 read as zero.
- R4: The status word lives at offset 0x2C and is read-only. Bit 11 is set while the transmit FIFO holds data or `tx_busy` is high. Bit 4 is set when the transmit FIFO is full. Bit 1 is set when the receive FIFO is empty. All other bits read as zero, and writes to this offset have no effect.
- R5: A write to offset 0x30 appends `req_wdata[7:0]` to the 16-entry transmit FIFO. While that FIFO is full the write is dropped and the queued bytes are left unchanged.
- R6: A read of offset 0x30 returns the oldest received byte in bits 7:0 and removes it. When the receive FIFO is empty the read returns zero and removes nothing.
- R7: Any other offset reads as zero and ignores writes. This includes offsets that are not a multiple of four.
- R8: `tx_avail` is high when transmit is enabled and the transmit FIFO is not empty. `tx_data` shows the oldest queued byte. `tx_pop` removes that byte only while `tx_avail` is high.
- R9: `rx_push` stores `rx_data` only while receive is enabled and the receive FIFO holds fewer than 16 bytes. Otherwise the byte is dropped.
- R10: `req_ready` is always high. Every request gives `rsp_valid` high in the next cycle, and `rsp_valid` is low in every other cycle. `rsp_rdata` is zero except in the response to a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present, one cycle after the request |
| rsp_rdata | output | 32 | Read data |
| tx_en | output | 1 | Transmit path enabled |
| rx_en | output | 1 | Receive path enabled |
| mode_cfg | output | 11 | Stored line-format word |
| tx_data | output | 8 | Oldest byte waiting to be sent |
| tx_avail | output | 1 | A byte is ready for the transmitter |
| tx_pop | input | 1 | Transmitter takes `tx_data` |
| tx_busy | input | 1 | Transmit shifter is still sending |
| rx_data | input | 8 | Byte from the receive shifter |
| rx_push | input | 1 | `rx_data` is valid this cycle |

## Verification
A wrong FIFO pointer or count shows up on `tx_data` in the very next cycle, or in the next data-port read after a receive. In both cases the byte order differs from the bench's queue. A flush bit that fails to clear reads back nonzero two cycles after the control write, and it also keeps the transmit queue empty, so later pushes never reach `tx_avail`. A wrong full or empty flag shows up in the status word, or as a byte that is lost or duplicated when the queue is drained. The bench compares every output against its reference model on every cycle, so such a fault surfaces within a few cycles of the access that exposes it.

// File: rtl/uart_csr_pkg.sv
// Shared constants for the serial port register front end: register
// offsets, bit positions inside the control and status words, widths and
// the decoded register selector.
package uart_csr_pkg;
    localparam int DATA_W    = 32;
    localparam int BYTE_W    = 8;
    localparam int CTRL_W    = 9;
    localparam int MODE_W    = 11;
    localparam int STAT_W    = 12;

    localparam int OFS_CTRL  = 'h00;
    localparam int OFS_MODE  = 'h04;
    localparam int OFS_STAT  = 'h2C;
    localparam int OFS_DATA  = 'h30;

    localparam int CB_TX_EN  = 4;
    localparam int CB_RX_EN  = 2;
    localparam int CB_TX_FL  = 1;
    localparam int CB_RX_FL  = 0;

    localparam int SB_TX_ACT = 11;
    localparam int SB_TX_FUL = 4;
    localparam int SB_RX_EMP = 1;

    localparam logic [MODE_W-1:0] MODE_RESET = 11'h020;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_MODE,
        SEL_STAT,
        SEL_DATA
    } reg_sel_e;
endpackage

// File: rtl/uart_byte_fifo.sv
// Synchronous byte queue with a flush input.
// Assumes: push when full and pop when empty are ignored; flush wins over
// push and pop in the same cycle; rdata shows the head entry (undefined
// content when empty). Any DEPTH >= 2 is allowed.
module uart_byte_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             full,
    output logic             empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] cnt;
    logic             do_push, do_pop;

    assign full    = (cnt == CNT_W'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_ptr];

    // Pointer and occupancy tracking, cleared by reset or flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            cnt <= cnt + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    // Storage write; content needs no reset.
    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wr_ptr] <= wdata;
    end

    // R5
    // full queue with a push and nothing leaving stays full, no wrap
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> (full && $stable(rd_ptr)));

    // R6
    // an empty queue never goes negative on a pop
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push && !flush) |=> empty);

    // R2
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);
endmodule

// File: rtl/uart_csr_status.sv
// Builds the read-only channel status word from the queue flags and the
// transmit shifter busy input. Purely combinational.
module uart_csr_status
    import uart_csr_pkg::*;
(
    input  logic              tx_empty,
    input  logic              tx_full,
    input  logic              rx_empty,
    input  logic              tx_busy,
    output logic [STAT_W-1:0] stat_word
);
    // Place each flag at its bit position; other bits stay zero.
    always_comb begin
        stat_word            = '0;
        stat_word[SB_TX_ACT] = !tx_empty || tx_busy;
        stat_word[SB_TX_FUL] = tx_full;
        stat_word[SB_RX_EMP] = rx_empty;
    end
endmodule

// File: rtl/uart_csr_regs.sv
// Address decode, control and line-format storage, data port strobes and
// the registered response path.
// Assumes: every request is accepted in the cycle it is presented; reads
// sample state from before the clock edge that takes the request.
module uart_csr_regs
    import uart_csr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic [STAT_W-1:0] stat_word,
    input  logic [BYTE_W-1:0] rx_head,
    input  logic              rx_empty,
    input  logic              tx_full,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic [MODE_W-1:0] mode_q,
    output logic              tx_push,
    output logic              rx_pop
);
    localparam logic [CTRL_W-1:0] FLUSH_MASK =
        CTRL_W'((1 << CB_TX_FL) | (1 << CB_RX_FL));

    reg_sel_e          sel;
    logic              wr_hit, rd_hit, ctrl_wr;
    logic [DATA_W-1:0] rd_mux;
    logic              unused_wdata;

    assign unused_wdata = ^req_wdata[DATA_W-1:CTRL_W];

    // Map the byte offset to a register; anything else is unmapped.
    always_comb begin
        if      (req_addr == ADDR_W'(OFS_CTRL)) sel = SEL_CTRL;
        else if (req_addr == ADDR_W'(OFS_MODE)) sel = SEL_MODE;
        else if (req_addr == ADDR_W'(OFS_STAT)) sel = SEL_STAT;
        else if (req_addr == ADDR_W'(OFS_DATA)) sel = SEL_DATA;
        else                                    sel = SEL_NONE;
    end

    assign wr_hit  = req_valid && req_write;
    assign rd_hit  = req_valid && !req_write;
    assign ctrl_wr = wr_hit && (sel == SEL_CTRL);
    assign tx_push = wr_hit && (sel == SEL_DATA) && !tx_full;
    assign rx_pop  = rd_hit && (sel == SEL_DATA) && !rx_empty;

    // Control word: a write loads it, otherwise the flush bits drop.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_wr) ctrl_q <= req_wdata[CTRL_W-1:0];
        else              ctrl_q <= ctrl_q & ~FLUSH_MASK;
    end

    // Line-format word: plain storage with a non-zero reset value.
    always_ff @(posedge clk) begin
        if (!rst_n)                         mode_q <= MODE_RESET;
        else if (wr_hit && sel == SEL_MODE) mode_q <= req_wdata[MODE_W-1:0];
    end

    // Read data selection from pre-edge state.
    always_comb begin
        case (sel)
            SEL_CTRL: rd_mux = DATA_W'(ctrl_q);
            SEL_MODE: rd_mux = DATA_W'(mode_q);
            SEL_STAT: rd_mux = DATA_W'(stat_word);
            SEL_DATA: rd_mux = rx_empty ? '0 : DATA_W'(rx_head);
            default:  rd_mux = '0;
        endcase
    end

    // One response per request, one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_rdata <= rd_hit ? rd_mux : '0;
        end
    end

    // R10
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R10
    rsp_only_on_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && rsp_rdata == '0));

    // R2
    flush_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(ctrl_q & FLUSH_MASK)) && !ctrl_wr) |=> ((ctrl_q & FLUSH_MASK) == '0));
endmodule

// File: rtl/uart_csr_frontend.sv
// Register front end of a serial port: register block, status assembly
// and one byte FIFO per direction.
// Assumes: the shift engines pop only while tx_avail is high (extra pops
// are ignored) and present received bytes with a one-cycle rx_push.
module uart_csr_frontend
    import uart_csr_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int FIFO_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              tx_en,
    output logic              rx_en,
    output logic [MODE_W-1:0] mode_cfg,
    output logic [BYTE_W-1:0] tx_data,
    output logic              tx_avail,
    input  logic              tx_pop,
    input  logic              tx_busy,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_push
);
    logic [CTRL_W-1:0] ctrl_q;
    logic [STAT_W-1:0] stat_word;
    logic [BYTE_W-1:0] rx_head;
    logic              tx_full, tx_empty, rx_full, rx_empty;
    logic              tx_push, rx_pop, tx_flush, rx_flush;
    logic              unused_rx_full;

    assign req_ready      = 1'b1;
    assign tx_en          = ctrl_q[CB_TX_EN];
    assign rx_en          = ctrl_q[CB_RX_EN];
    assign tx_flush       = ctrl_q[CB_TX_FL];
    assign rx_flush       = ctrl_q[CB_RX_FL];
    assign tx_avail       = tx_en && !tx_empty;
    assign unused_rx_full = rx_full;

    uart_csr_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .stat_word (stat_word),
        .rx_head   (rx_head),
        .rx_empty  (rx_empty),
        .tx_full   (tx_full),
        .ctrl_q    (ctrl_q),
        .mode_q    (mode_cfg),
        .tx_push   (tx_push),
        .rx_pop    (rx_pop)
    );

    uart_byte_fifo #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (tx_flush),
        .push  (tx_push),
        .wdata (req_wdata[BYTE_W-1:0]),
        .pop   (tx_pop && tx_avail),
        .rdata (tx_data),
        .full  (tx_full),
        .empty (tx_empty)
    );

    uart_byte_fifo #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (rx_flush),
        .push  (rx_push && rx_en),
        .wdata (rx_data),
        .pop   (rx_pop),
        .rdata (rx_head),
        .full  (rx_full),
        .empty (rx_empty)
    );

    uart_csr_status u_status (
        .tx_empty  (tx_empty),
        .tx_full   (tx_full),
        .rx_empty  (rx_empty),
        .tx_busy   (tx_busy),
        .stat_word (stat_word)
    );

    // R2
    tx_flush_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_flush |=> !tx_avail);

    // R8
    // the head byte stays put while nothing is taken or flushed
    tx_head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_avail && !tx_pop && !tx_flush) |=> (tx_avail || !tx_en) && $stable(tx_data));

    // R4
    busy_shows_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_busy |-> stat_word[SB_TX_ACT]);
endmodule

// File: tb/uart_csr_frontend_test.sv
module uart_csr_frontend_test;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready, rsp_valid, tx_en, rx_en, tx_avail;
    logic [31:0] rsp_rdata;
    logic [10:0] mode_cfg;
    logic [7:0]  tx_data;
    logic        tx_pop = 1'b0, tx_busy = 1'b0, rx_push = 1'b0;
    logic [7:0]  rx_data = '0;

    int compared = 0, mismatched = 0;
    bit done = 0;

    always #4 clk = ~clk;

    uart_csr_frontend uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .tx_en(tx_en), .rx_en(rx_en),
        .mode_cfg(mode_cfg), .tx_data(tx_data), .tx_avail(tx_avail), .tx_pop(tx_pop),
        .tx_busy(tx_busy), .rx_data(rx_data), .rx_push(rx_push)
    );

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Behavioural reference model, advanced on each rising edge.
    logic [8:0]  m_ctrl;
    logic [10:0] m_mode;
    logic [7:0]  m_txq[$];
    logic [7:0]  m_rxq[$];
    logic        m_rsp_v;
    logic [31:0] m_rsp_d;

    always @(posedge clk) begin : model
        logic [31:0] stat, rd;
        int txn, rxn;
        if (!rst_n) begin
            m_ctrl = '0; m_mode = 11'h020; m_txq.delete(); m_rxq.delete();
            m_rsp_v = 0; m_rsp_d = '0;
        end else begin
            txn = m_txq.size(); rxn = m_rxq.size();
            stat = '0;
            stat[11] = (txn != 0) || tx_busy;
            stat[4]  = (txn == DEPTH);
            stat[1]  = (rxn == 0);
            case (req_addr)
                8'h00: rd = {23'd0, m_ctrl};
                8'h04: rd = {21'd0, m_mode};
                8'h2C: rd = stat;
                8'h30: rd = (rxn != 0) ? {24'd0, m_rxq[0]} : 32'd0;
                default: rd = '0;
            endcase
            m_rsp_v = req_valid;
            m_rsp_d = (req_valid && !req_write) ? rd : 32'd0;
            if (m_ctrl[1]) m_txq.delete();
            else begin
                if (tx_pop && m_ctrl[4] && txn != 0) void'(m_txq.pop_front());
                if (req_valid && req_write && req_addr == 8'h30 && txn < DEPTH)
                    m_txq.push_back(req_wdata[7:0]);
            end
            if (m_ctrl[0]) m_rxq.delete();
            else begin
                if (req_valid && !req_write && req_addr == 8'h30 && rxn != 0)
                    void'(m_rxq.pop_front());
                if (rx_push && m_ctrl[2] && rxn < DEPTH) m_rxq.push_back(rx_data);
            end
            if (req_valid && req_write && req_addr == 8'h00) m_ctrl = req_wdata[8:0];
            else m_ctrl[1:0] = 2'b00;
            if (req_valid && req_write && req_addr == 8'h04) m_mode = req_wdata[10:0];
        end
    end

    // Compare every output against the model away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R10", "req_ready", {31'd0, req_ready}, 32'd1);
            check("R10", "rsp_valid", {31'd0, rsp_valid}, {31'd0, m_rsp_v});
            check("R10", "rsp_rdata", rsp_rdata, m_rsp_d);
            check("R1", "tx_en", {31'd0, tx_en}, {31'd0, m_ctrl[4]});
            check("R1", "rx_en", {31'd0, rx_en}, {31'd0, m_ctrl[2]});
            check("R3", "mode_cfg", {21'd0, mode_cfg}, {21'd0, m_mode});
            check("R8", "tx_avail", {31'd0, tx_avail},
                  {31'd0, m_ctrl[4] && m_txq.size() != 0});
            if (m_txq.size() != 0)
                check("R8", "tx_data", {24'd0, tx_data}, {24'd0, m_txq[0]});
        end
    end

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 0; req_write = 0;
        check("R10", "write response", {rsp_valid, rsp_rdata[30:0]}, 32'h8000_0000);
    endtask

    task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = a;
        @(negedge clk);
        req_valid = 0;
        check(tag, "rsp_valid on read", {31'd0, rsp_valid}, 32'd1);
        check(tag, "read data", rsp_rdata, exp);
    endtask

    task automatic pulse_pop();
        @(negedge clk); tx_pop = 1;
        @(negedge clk); tx_pop = 0;
    endtask

    task automatic rx_byte(logic [7:0] b);
        @(negedge clk); rx_push = 1; rx_data = b;
        @(negedge clk); rx_push = 0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin : stimulus
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1;

        // R1 R3 R4 R6 reset state
        rd(8'h00, 32'h0, "R1");
        rd(8'h04, 32'h20, "R3");
        rd(8'h2C, 32'h002, "R4");
        rd(8'h30, 32'h0, "R6");

        // R1 implemented bits only; R3 mode width
        wr(8'h00, 32'hFFFF_FFEC);
        rd(8'h00, 32'h1EC, "R1");
        wr(8'h00, 32'h14);
        rd(8'h00, 32'h14, "R1");
        wr(8'h04, 32'hFFFF_FFFF);
        rd(8'h04, 32'h7FF, "R3");
        wr(8'h04, 32'h20);

        // R4 read-only status, busy flag
        wr(8'h2C, 32'hFFF);
        rd(8'h2C, 32'h002, "R4");
        @(negedge clk) tx_busy = 1;
        rd(8'h2C, 32'h802, "R4");
        @(negedge clk) tx_busy = 0;

        // R8 queue and take bytes
        wr(8'h30, 32'hA1); wr(8'h30, 32'hB2); wr(8'h30, 32'hC3);
        check("R8", "head byte", {24'd0, tx_data}, 32'hA1);
        rd(8'h2C, 32'h802, "R4");
        pulse_pop();
        check("R8", "head after pop", {24'd0, tx_data}, 32'hB2);
        wr(8'h00, 32'h04);
        check("R8", "avail when disabled", {31'd0, tx_avail}, 32'd0);
        pulse_pop();
        wr(8'h00, 32'h14);
        check("R8", "pop ignored when disabled", {24'd0, tx_data}, 32'hB2);

        // R5 fill to full, overflow dropped
        for (int i = 0; i < 20; i++) wr(8'h30, 32'h10 + i);
        rd(8'h2C, 32'h812, "R5");
        check("R5", "head after fill", {24'd0, tx_data}, 32'hB2);
        pulse_pop();
        check("R5", "second byte", {24'd0, tx_data}, 32'hC3);
        for (int i = 0; i < 14; i++) begin
            pulse_pop();
            check("R5", "drain order", {24'd0, tx_data}, 32'h10 + i);
        end
        pulse_pop();
        check("R5", "drained", {31'd0, tx_avail}, 32'd0);

        // R6 receive and read back
        rx_byte(8'h55); rx_byte(8'h66); rx_byte(8'h77);
        rd(8'h2C, 32'h000, "R4");
        rd(8'h30, 32'h55, "R6");
        rd(8'h30, 32'h66, "R6");
        rd(8'h30, 32'h77, "R6");
        rd(8'h30, 32'h0, "R6");

        // R9 disabled receive and full queue drop bytes
        wr(8'h00, 32'h10);
        rx_byte(8'h99);
        wr(8'h00, 32'h14);
        rd(8'h30, 32'h0, "R9");
        for (int i = 0; i < 18; i++) rx_byte(8'h40 + 8'(i));
        for (int i = 0; i < 16; i++) rd(8'h30, 32'h40 + i, "R9");
        rd(8'h30, 32'h0, "R9");

        // R7 unmapped and misaligned offsets
        rd(8'h08, 32'h0, "R7");
        rd(8'h31, 32'h0, "R7");
        rd(8'h34, 32'h0, "R7");
        wr(8'h08, 32'hFFFF);
        wr(8'h01, 32'h03);
        wr(8'h31, 32'h5A);
        rd(8'h00, 32'h14, "R7");
        check("R7", "misaligned data write", {31'd0, tx_avail}, 32'd0);

        // R2 flush bits empty both queues and clear themselves
        wr(8'h30, 32'hE1); wr(8'h30, 32'hE2);
        rx_byte(8'hD1); rx_byte(8'hD2);
        rd(8'h2C, 32'h800, "R2");
        wr(8'h00, 32'h17);
        rd(8'h00, 32'h14, "R2");
        rd(8'h2C, 32'h002, "R2");
        check("R2", "tx after flush", {31'd0, tx_avail}, 32'd0);
        rd(8'h30, 32'h0, "R2");

        // mixed traffic, model compared every cycle
        for (int n = 0; n < 4000; n++) begin
            @(negedge clk);
            tx_pop  = ($urandom_range(0, 2) == 0);
            tx_busy = ($urandom_range(0, 3) == 0);
            rx_push = ($urandom_range(0, 2) == 0);
            rx_data = 8'($urandom);
            req_valid = ($urandom_range(0, 1) == 1);
            req_write = ($urandom_range(0, 1) == 1);
            case ($urandom_range(0, 9))
                0: req_addr = 8'h00;
                1: req_addr = 8'h04;
                2, 3: req_addr = 8'h2C;
                4, 5, 6, 7: req_addr = 8'h30;
                8: req_addr = 8'h08;
                default: req_addr = 8'h31;
            endcase
            req_wdata = $urandom;
            if (req_addr == 8'h00 && $urandom_range(0, 3) != 0)
                req_wdata = 32'h14 | 32'($urandom_range(0, 3) == 0);
        end
        @(negedge clk);
        req_valid = 0; tx_pop = 0; rx_push = 0; tx_busy = 0;
        @(negedge clk);
        finish_run();
    end
endmodule